// File: doc/BRIEF.md
# Reconfigurable Trellis State-Metric Recursion Unit

This block advances the state metrics of a max-log trellis decoder by one trellis step per clock. It holds eight signed state metrics. Each step takes a set of branch metrics and computes, for every state, the largest sum of a connected old state metric and the metric of the branch that links them. It then rebases all results against state 0. The same bank of eight four-input add-compare-select units serves three trellises:

- an 8-state code with 2-bit input symbols (four branches per state);
- an 8-state binary code (two branches per state);
- a 2-state binary code of the kind used for parity-check processing.

A mode input selects the trellis and a direction input selects forward or backward recursion. Both are read on every step. A caller can therefore switch code type between blocks, or even between steps, with no other action. A routing network in front of the units picks, for each unit and branch slot, which old metric and which branch metric it receives. An init pulse seeds the metrics before a new recursion starts.

Top module: `smr_unit`

## Requirements
- R1: Reset, and a cycle with `initPulse` high, set state 0 to 0 and states 1 to 7 to -256 at the next clock edge, with `validOut` low in the following cycle.
- R2: A cycle with `stepIn` high and `initPulse` low updates `metOut` at the next clock edge and raises `validOut` for exactly the cycle after that edge.
- R3: With `modeSel`=0 (8-state, 2-bit symbols), the transition from state s under symbol u (0..3) goes to state ({s[1:0],s[2]}) XOR L(u). Here L(0)=0, L(1)=3, L(2)=6 and L(3)=5. Forward, each new metric is the maximum over its four incoming transitions of old metric plus branch metric.
- R4: With `modeSel`=1 (8-state binary), the transition from state s under bit b goes to state {s[1:0], b^s[2]^s[1]}. Only b=0 and b=1 exist.
- R5: With `modeSel`=2 or 3 (2-state binary), the transition from state s under bit b goes to s^b. Only states 0 and 1 are updated, and states 2 to 7 keep their values across steps.
- R6: With `dirBwd`=1, each state's new metric is the maximum over its outgoing transitions (same trellis as R3 to R5) of the metric of the destination state plus the branch metric.
- R7: Each metric-plus-branch sum saturates to the range -512..511 instead of wrapping.
- R8: After every step, each updated state holds its raw maximum minus the raw maximum of state 0, saturated to -512..511, so state 0 reads 0.
- R9: The branch metric of the transition from state s under input u sits at `gammaIn[8*(4*s+u) +: 8]` (signed), in both directions. In the binary modes the entries for u=2 and u=3 have no effect.
- R10: A change of `modeSel` or `dirBwd` between steps takes effect on the next step and starts from the metrics already held, with no init needed.
- R11: When `initPulse` and `stepIn` are high in the same cycle, the init values are loaded and `validOut` stays low.
- R12: In a cycle without `stepIn` or `initPulse`, `metOut` keeps its value and `validOut` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| initPulse | input | 1 | Load starting metrics |
| stepIn | input | 1 | Perform one recursion step |
| modeSel | input | 2 | Trellis: 0 = 8-state 2-bit symbols, 1 = 8-state binary, 2/3 = 2-state binary |
| dirBwd | input | 1 | 0 = forward, 1 = backward recursion |
| gammaIn | input | 256 | 32 signed 8-bit branch metrics, entry 4*s+u |
| metOut | output | 80 | 8 signed 10-bit state metrics, state k at bits 10*k +: 10 |
| validOut | output | 1 | High the cycle after a step |

## Verification
The assertions take for granted that the metrics held before a step stem from an init or reset and later steps, so that state 0 enters each step at zero. They also take for granted that `initPulse` overrides `stepIn`. The stimulus keeps within this: every run begins with an init, and later changes of mode or direction happen only between steps. Branch metrics span the full signed 8-bit range, including runs of constant extremes and alternating extremes, which drive the sums towards the saturation bounds. In the binary modes the unused branch entries carry values that would change the result if they were read.

// File: rtl/smr_pkg.sv
package smr_pkg;

  localparam int NUM_STATES = 8;
  localparam int NUM_BRANCH = 4;
  localparam int NUM_GAMMA  = NUM_STATES * NUM_BRANCH;

  typedef enum logic [1:0] {
    MODE_QUAD8  = 2'd0,
    MODE_BIN8   = 2'd1,
    MODE_BIN2   = 2'd2,
    MODE_BIN2B  = 2'd3
  } mode_e;

  typedef struct packed {
    logic load;    // seed metrics
    logic step;    // advance one trellis step
    logic narrow;  // 2-state trellis
    logic quad;    // four branches per state
    logic bwd;     // backward direction
  } ctrl_s;

  function automatic logic [2:0] symLabel(input logic [1:0] u);
    return {u[1], u[0] ^ u[1], u[0]};
  endfunction

  function automatic logic [2:0] quadNext(input logic [2:0] s, input logic [1:0] u);
    return {s[1:0], s[2]} ^ symLabel(u);
  endfunction

  function automatic logic [2:0] quadPrev(input logic [2:0] n, input logic [1:0] u);
    logic [2:0] x;
    x = n ^ symLabel(u);
    return {x[0], x[2:1]};
  endfunction

  function automatic logic [2:0] binNext(input logic [2:0] s, input logic b);
    return {s[1:0], b ^ s[2] ^ s[1]};
  endfunction

endpackage

// File: rtl/smr_ctrl.sv
module smr_ctrl
  import smr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       initPulse,
  input  logic       stepIn,
  input  logic [1:0] modeSel,
  input  logic       dirBwd,
  output ctrl_s      ctl,
  output logic       validOut
);

  logic validQ;

  always_comb begin
    ctl.load   = initPulse;
    ctl.step   = stepIn & ~initPulse;
    ctl.narrow = modeSel[1];
    ctl.quad   = (mode_e'(modeSel) == MODE_QUAD8);
    ctl.bwd    = dirBwd;
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= ctl.step;
  end

  assign validOut = validQ;

  AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    (stepIn && !initPulse) |=> validOut); // R2

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!stepIn || initPulse) |=> !validOut); // R12

endmodule

// File: rtl/smr_acs.sv
module smr_acs #(
  parameter int MW = 10,
  parameter int GW = 8,
  parameter int NB = 4
) (
  input  logic signed [MW-1:0] metIn [NB],
  input  logic signed [GW-1:0] gamIn [NB],
  input  logic [NB-1:0]        enIn,
  output logic signed [MW-1:0] best
);

  localparam logic signed [MW:0]   SUM_HI = (MW+1)'((2 ** (MW-1)) - 1);
  localparam logic signed [MW:0]   SUM_LO = (MW+1)'(-(2 ** (MW-1)));
  localparam logic signed [MW-1:0] MET_HI = MW'((2 ** (MW-1)) - 1);
  localparam logic signed [MW-1:0] MET_LO = MW'(-(2 ** (MW-1)));

  logic signed [MW-1:0] cand [NB];

  for (genvar u = 0; u < NB; u++) begin : g_add
    logic signed [MW:0] sum;
    assign sum = $signed({metIn[u][MW-1], metIn[u]})
               + $signed({{(MW-GW+1){gamIn[u][GW-1]}}, gamIn[u]});
    always_comb begin
      if (sum > SUM_HI)      cand[u] = MET_HI;
      else if (sum < SUM_LO) cand[u] = MET_LO;
      else                   cand[u] = sum[MW-1:0];
    end
  end

  always_comb begin
    best = MET_LO;
    for (int u = 0; u < NB; u++) begin
      if (enIn[u] && (cand[u] > best)) best = cand[u];
    end
  end

endmodule

// File: rtl/smr_datapath.sv
module smr_datapath
  import smr_pkg::*;
#(
  parameter int MW       = 10,
  parameter int GW       = 8,
  parameter int INIT_NEG = -256
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ctrl_s                     ctl,
  input  logic [NUM_GAMMA*GW-1:0]   gammaIn,
  output logic [NUM_STATES*MW-1:0]  metOut
);

  localparam int NS = NUM_STATES;
  localparam int NB = NUM_BRANCH;
  localparam logic signed [MW-1:0] INIT_M = MW'(INIT_NEG);
  localparam logic signed [MW:0]   DIF_HI = (MW+1)'((2 ** (MW-1)) - 1);
  localparam logic signed [MW:0]   DIF_LO = (MW+1)'(-(2 ** (MW-1)));
  localparam logic signed [MW-1:0] MET_HI = MW'((2 ** (MW-1)) - 1);
  localparam logic signed [MW-1:0] MET_LO = MW'(-(2 ** (MW-1)));

  logic signed [MW-1:0] metQ  [NS];
  logic signed [MW-1:0] newM  [NS];
  logic signed [MW-1:0] normM [NS];
  logic signed [GW-1:0] gam   [NUM_GAMMA];
  logic signed [MW-1:0] candM [NS][NB];
  logic signed [GW-1:0] candG [NS][NB];
  logic [NB-1:0]        candEn [NS];

  for (genvar i = 0; i < NUM_GAMMA; i++) begin : g_gam
    assign gam[i] = gammaIn[i*GW +: GW];
  end

  // Feedback routing: per unit and branch slot, pick old metric and branch metric
  for (genvar k = 0; k < NS; k++) begin : g_unit
    localparam logic [2:0] KI = 3'(k);
    for (genvar u = 0; u < NB; u++) begin : g_slot
      localparam logic [1:0] UI = 2'(u);
      logic [2:0] srcIdx;
      logic [4:0] gIdx;
      always_comb begin
        if (ctl.bwd) begin
          if (ctl.quad)        srcIdx = quadNext(KI, UI);
          else if (ctl.narrow) srcIdx = {2'b00, KI[0] ^ UI[0]};
          else                 srcIdx = binNext(KI, UI[0]);
          gIdx = {KI, UI};
        end else begin
          if (ctl.quad) begin
            srcIdx = quadPrev(KI, UI);
            gIdx   = {srcIdx, UI};
          end else if (ctl.narrow) begin
            srcIdx = {2'b00, KI[0] ^ UI[0]};
            gIdx   = {srcIdx, UI};
          end else begin
            srcIdx = {UI[0], KI[2:1]};
            gIdx   = {srcIdx, 1'b0, KI[0] ^ UI[0] ^ KI[2]};
          end
        end
      end
      assign candM[k][u]  = metQ[srcIdx];
      assign candG[k][u]  = gam[gIdx];
      assign candEn[k][u] = ctl.quad || (u < 2);
    end

    smr_acs #(.MW(MW), .GW(GW), .NB(NB)) u_acs (
      .metIn (candM[k]),
      .gamIn (candG[k]),
      .enIn  (candEn[k]),
      .best  (newM[k])
    );
  end

  // Normalization: rebase every state on state 0
  for (genvar k = 0; k < NS; k++) begin : g_norm
    logic signed [MW:0] dif;
    assign dif = $signed({newM[k][MW-1], newM[k]}) - $signed({newM[0][MW-1], newM[0]});
    always_comb begin
      if (dif > DIF_HI)      normM[k] = MET_HI;
      else if (dif < DIF_LO) normM[k] = MET_LO;
      else                   normM[k] = dif[MW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NS; k++) begin
      if (rst || ctl.load) begin
        metQ[k] <= (k == 0) ? '0 : INIT_M;
      end else if (ctl.step && (!ctl.narrow || k < 2)) begin
        metQ[k] <= normM[k];
      end
    end
  end

  for (genvar k = 0; k < NS; k++) begin : g_out
    assign metOut[k*MW +: MW] = metQ[k];
  end

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> (metQ[0] == '0 && metQ[1] == INIT_M && metQ[NS-1] == INIT_M)); // R1

  AST_REF_ZERO: assert property (@(posedge clk) disable iff (rst)
    ctl.step |=> (metOut[MW-1:0] == '0)); // R8

  AST_NARROW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctl.step && ctl.narrow) |=> $stable(metOut[NS*MW-1:2*MW])); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ctl.step && !ctl.load) |=> $stable(metOut)); // R12

endmodule

// File: rtl/smr_unit.sv
module smr_unit
  import smr_pkg::*;
#(
  parameter int MW       = 10,
  parameter int GW       = 8,
  parameter int INIT_NEG = -256
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      initPulse,
  input  logic                      stepIn,
  input  logic [1:0]                modeSel,
  input  logic                      dirBwd,
  input  logic [NUM_GAMMA*GW-1:0]   gammaIn,
  output logic [NUM_STATES*MW-1:0]  metOut,
  output logic                      validOut
);

  ctrl_s ctl;

  smr_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .initPulse (initPulse),
    .stepIn    (stepIn),
    .modeSel   (modeSel),
    .dirBwd    (dirBwd),
    .ctl       (ctl),
    .validOut  (validOut)
  );

  smr_datapath #(.MW(MW), .GW(GW), .INIT_NEG(INIT_NEG)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .gammaIn (gammaIn),
    .metOut  (metOut)
  );

endmodule

// File: tb/sim_smr_unit.sv
module sim_smr_unit;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         initPulse = 1'b0;
  logic         stepIn = 1'b0;
  logic [1:0]   modeSel = 2'd0;
  logic         dirBwd = 1'b0;
  logic [255:0] gammaIn = '0;
  logic [79:0]  metOut;
  logic         validOut;

  int checks = 0;
  int failures = 0;
  int model [8];
  int gm [32];

  always #5 clk = ~clk;

  smr_unit u0 (
    .clk(clk), .rst(rst), .initPulse(initPulse), .stepIn(stepIn),
    .modeSel(modeSel), .dirBwd(dirBwd), .gammaIn(gammaIn),
    .metOut(metOut), .validOut(validOut)
  );

  function automatic int sat(input int v);
    if (v > 511) return 511;
    if (v < -512) return -512;
    return v;
  endfunction

  function automatic int nxt(input int mode, input int s, input int u);
    int r, f;
    if (mode == 0) begin
      r = ((s << 1) & 6) | (s >> 2);
      f = (u == 0) ? 0 : (u == 1) ? 3 : (u == 2) ? 6 : 5;
      return r ^ f;
    end else if (mode == 1) begin
      return ((s & 3) << 1) | (u ^ ((s >> 2) & 1) ^ ((s >> 1) & 1));
    end
    return s ^ u;
  endfunction

  task automatic modelInit();
    for (int k = 0; k < 8; k++) model[k] = (k == 0) ? 0 : -256;
  endtask

  task automatic modelStep(input int mode, input int bwd);
    int ns, nb, ref0;
    int tmp [8];
    ns = (mode >= 2) ? 2 : 8;
    nb = (mode == 0) ? 4 : 2;
    for (int k = 0; k < 8; k++) tmp[k] = -100000;
    for (int s = 0; s < ns; s++) begin
      for (int u = 0; u < nb; u++) begin
        int n, c;
        n = nxt(mode, s, u);
        if (bwd != 0) begin
          c = sat(model[n] + gm[s*4+u]);
          if (c > tmp[s]) tmp[s] = c;
        end else begin
          c = sat(model[s] + gm[s*4+u]);
          if (c > tmp[n]) tmp[n] = c;
        end
      end
    end
    ref0 = tmp[0];
    for (int k = 0; k < ns; k++) model[k] = sat(tmp[k] - ref0);
  endtask

  task automatic checkOut(input string tag, input bit expValid);
    bit bad = 0;
    checks++;
    for (int k = 0; k < 8; k++) begin
      int got;
      got = int'($signed(metOut[k*10 +: 10]));
      if (got != model[k] && !bad) begin
        bad = 1;
        $display("FAIL %s state %0d actual=%0d expected=%0d", tag, k, got, model[k]);
      end
    end
    if (validOut !== expValid && !bad) begin
      bad = 1;
      $display("FAIL %s validOut actual=%0b expected=%0b", tag, validOut, expValid);
    end
    if (bad) failures++;
  endtask

  task automatic driveGamma();
    for (int i = 0; i < 32; i++) gammaIn[i*8 +: 8] = 8'(gm[i]);
  endtask

  task automatic doInit(input string tag);
    @(negedge clk);
    initPulse = 1'b1;
    @(negedge clk);
    initPulse = 1'b0;
    modelInit();
    checkOut(tag, 1'b0);
  endtask

  task automatic doStep(input int mode, input int bwd, input string tag);
    @(negedge clk);
    modeSel = 2'(mode);
    dirBwd = bwd[0];
    driveGamma();
    stepIn = 1'b1;
    @(negedge clk);
    stepIn = 1'b0;
    modelStep(mode, bwd);
    checkOut(tag, 1'b1);
  endtask

  function automatic string tagFor(input int mode, input int bwd);
    string t;
    t = (mode == 0) ? "R3 R2 R8" : (mode == 1) ? "R4 R9 R2 R8" : "R5 R9 R2 R8";
    if (bwd != 0) t = {t, " R6"};
    return t;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    modelInit();
    checkOut("R1 reset", 1'b0);

    // Random sweeps over every trellis and direction
    for (int mode = 0; mode < 4; mode++) begin
      for (int bwd = 0; bwd < 2; bwd++) begin
        doInit("R1 init");
        for (int n = 0; n < 30; n++) begin
          for (int i = 0; i < 32; i++) gm[i] = int'($urandom_range(0, 255)) - 128;
          doStep(mode, bwd, tagFor(mode, bwd));
        end
      end
    end

    // Extreme branch metrics toward saturation; unused binary entries loud
    for (int mode = 0; mode < 3; mode++) begin
      for (int bwd = 0; bwd < 2; bwd++) begin
        for (int pat = 0; pat < 4; pat++) begin
          doInit("R1 init");
          for (int n = 0; n < 6; n++) begin
            for (int i = 0; i < 32; i++) begin
              case (pat)
                0: gm[i] = 127;
                1: gm[i] = -128;
                2: gm[i] = ((i & 3) >= 2) ? 127 : (((i + n) & 1) != 0 ? 127 : -128);
                default: gm[i] = ((i >> 2) == n % 8) ? 127 : -128;
              endcase
            end
            doStep(mode, bwd, "R7 R9 saturation");
          end
        end
      end
    end

    // Mode and direction changes between steps, no init
    doInit("R1 init");
    for (int n = 0; n < 60; n++) begin
      int m, d;
      m = int'($urandom_range(0, 3));
      d = int'($urandom_range(0, 1));
      for (int i = 0; i < 32; i++) gm[i] = int'($urandom_range(0, 255)) - 128;
      doStep(m, d, "R10 R5 on-the-fly");
    end

    // Idle cycle holds metrics, valid drops
    @(negedge clk);
    checkOut("R12 idle", 1'b0);

    // Init and step together: init wins
    @(negedge clk);
    for (int i = 0; i < 32; i++) gm[i] = 100;
    driveGamma();
    modeSel = 2'd0;
    stepIn = 1'b1;
    initPulse = 1'b1;
    @(negedge clk);
    stepIn = 1'b0;
    initPulse = 1'b0;
    modelInit();
    checkOut("R11 init priority", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule